// File: doc/BRIEF.md
# Power-fail write-protect supervisor

This block sits between a host and a byte-wide static memory array and decides, cycle by cycle, whether the host's chip-enable and write-enable strobes may reach the array. It takes three raw supply-status bits from external comparators: supply under the deselect threshold, supply under the battery switchover threshold, and backup battery under its low limit. Each bit passes through a two-flop synchroniser and a glitch filter before the supervisor acts on it. A short noise spike on the supply therefore cannot toggle the protection.

While the supply is low the array is deselected. Both strobes are held inactive and any host activity has no effect. When the supply comes back, protection is held for a recovery interval counted by a prescaled cycle counter. A new dip before the interval ends sends the supervisor back to the powered-off state, and the count starts over. The battery-select output follows the filtered switchover bit and is independent of the other inputs. The battery level is sampled at each power-up. When the battery is low, a sticky status flag is raised. The next host write is silently swallowed, because write-enable is kept from the array while chip-enable passes. The flag clears once that write ends, and later writes go through. The interface is plain control and status. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pfail_guard`

## Requirements
- R1: During reset, `mem_desel`=1, `mem_ce_n`=1, `mem_we_n`=1, `batt_bad`=0, `recov_busy`=0 and `batt_sel`=1. The filtered supply-low and switchover bits reset to 1, and the battery-low bit resets to 0.
- R2: While `mem_desel` is 1, `mem_ce_n` and `mem_we_n` are both 1 whatever `host_ce_n` and `host_we_n` do.
- R3: A rise of `vcc_low_raw` that is held raises `mem_desel` after the (FILT_LEN+2)-th rising clock edge following the change. A pulse on any raw input lasting fewer than FILT_LEN cycles is ignored.
- R4: After `vcc_low_raw` falls and stays low, `mem_desel` falls after edge FILT_LEN+3+PRESCALE*REC_TICKS, where PRESCALE=CLK_KHZ and REC_TICKS=REC_MS. It is still 1 after the edge before that.
- R5: A filtered supply dip during the recovery interval returns the supervisor to the powered-off state (`recov_busy`=0, `mem_desel`=1). The full interval is counted again from the next recovery.
- R6: `batt_sel` equals the filtered `vcc_sw_raw`, with the same FILT_LEN+2 edge latency, and has no effect on `mem_desel`.
- R7: At each power-up, on the edge after the filtered supply-low bit falls, `batt_bad` loads the filtered battery-low bit: 1 if the battery is low, 0 if it is good.
- R8: While `batt_bad`=1, `mem_we_n` stays 1 even when `host_we_n`=0. The first host write (chip-enable and write-enable both low while selected) clears `batt_bad` on the edge after it ends. A later write then reaches `mem_we_n`.
- R9: With `mem_desel`=0 and `batt_bad`=0, `mem_ce_n`=`host_ce_n` and `mem_we_n`=`host_we_n` in the same cycle (combinational path).
- R10: `recov_busy` is 1 exactly while the recovery interval is being counted. It rises on the edge after the filtered supply-low bit falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_low_raw | input | 1 | Comparator: supply below deselect threshold |
| vcc_sw_raw | input | 1 | Comparator: supply below switchover threshold |
| batt_low_raw | input | 1 | Comparator: battery below low limit |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| mem_ce_n | output | 1 | Gated chip-enable to the array |
| mem_we_n | output | 1 | Gated write-enable to the array |
| mem_desel | output | 1 | Array deselected / write-protected |
| batt_sel | output | 1 | Storage powered from battery |
| recov_busy | output | 1 | Recovery interval in progress |
| batt_bad | output | 1 | Battery-not-OK status flag |

## Verification
The strobe gating is combinational. The bench drives the strobes at the falling edge and samples one time unit later, before the next rising edge. Supply and battery changes take effect FILT_LEN+2 edges after the raw change. Recovery ends FILT_LEN+3+PRESCALE*REC_TICKS edges after the raw supply recovers, and the flag clears one edge after a write ends. For each of these results, the bench counts rising edges from the falling edge where it drove the input. It checks the output at the falling edge after the edge just before the due edge, and again at the falling edge after the due edge itself.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_RECOVER = 2'd1,
    PS_ONLINE  = 2'd2
  } pwr_state_e;

  localparam int N_STATUS = 3;
  localparam int IDX_VLOW = 0;
  localparam int IDX_VSW  = 1;
  localparam int IDX_BATT = 2;
endpackage

// File: rtl/pf_sync_filter.sv
module pf_sync_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_o <= RST_VAL;
      cnt    <= '0;
    end else if (s2 == filt_o) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      filt_o <= s2;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  filt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_o != $past(filt_o)) |-> ($past(cnt) == CNT_LAST && $past(s2) == filt_o));
endmodule

// File: rtl/pf_recovery_timer.sv
module pf_recovery_timer
  import pf_pkg::*;
#(
  parameter int PRESCALE  = 100000,
  parameter int REC_TICKS = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vlow_i,
  output pwr_state_e state_o,
  output logic       pwrup_o
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam int TW = $clog2(REC_TICKS + 1);
  localparam logic [PW-1:0] PRE_MAX  = PW'(PRESCALE - 1);
  localparam logic [TW-1:0] TICK_MAX = TW'(REC_TICKS - 1);

  logic [PW-1:0] pre;
  logic [TW-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= PS_OFF;
      pre     <= '0;
      ticks   <= '0;
    end else begin
      case (state_o)
        PS_OFF: begin
          pre   <= '0;
          ticks <= '0;
          if (!vlow_i) state_o <= PS_RECOVER;
        end
        PS_RECOVER: begin
          if (vlow_i) begin
            state_o <= PS_OFF;
          end else if (pre == PRE_MAX) begin
            pre <= '0;
            if (ticks == TICK_MAX) state_o <= PS_ONLINE;
            else                   ticks   <= ticks + 1'b1;
          end else begin
            pre <= pre + 1'b1;
          end
        end
        PS_ONLINE: begin
          if (vlow_i) state_o <= PS_OFF;
        end
        default: state_o <= PS_OFF;
      endcase
    end
  end

  assign pwrup_o = (state_o == PS_OFF) && !vlow_i;

  // R4
  full_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_ONLINE && $past(state_o) == PS_RECOVER) |->
      ($past(pre) == PRE_MAX && $past(ticks) == TICK_MAX && !$past(vlow_i)));

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_RECOVER && $past(state_o) != PS_RECOVER) |->
      (pre == '0 && ticks == '0));
endmodule

// File: rtl/pf_batt_flag.sv
module pf_batt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrup_i,
  input  logic batt_low_i,
  input  logic wr_act_i,
  output logic bad_o
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      bad_o <= 1'b0;
    end else begin
      wr_q <= wr_act_i;
      if (pwrup_i)              bad_o <= batt_low_i;
      else if (wr_q && !wr_act_i) bad_o <= 1'b0;
    end
  end

  // R7
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_o) |-> $past(pwrup_i && batt_low_i));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bad_o) |-> ($past(pwrup_i) || ($past(wr_q) && !$past(wr_act_i))));
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pf_pkg::*;
#(
  parameter int CLK_KHZ  = 100000,
  parameter int REC_MS   = 40,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low_raw,
  input  logic vcc_sw_raw,
  input  logic batt_low_raw,
  input  logic host_ce_n,
  input  logic host_we_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_desel,
  output logic batt_sel,
  output logic recov_busy,
  output logic batt_bad
);
  localparam logic [N_STATUS-1:0] RST_VEC = 3'b011;

  logic [N_STATUS-1:0] raw_vec;
  logic [N_STATUS-1:0] filt_vec;
  pwr_state_e          pstate;
  logic                pwrup;
  logic                wr_act;

  assign raw_vec = {batt_low_raw, vcc_sw_raw, vcc_low_raw};

  for (genvar i = 0; i < N_STATUS; i++) begin : g_filt
    pf_sync_filter #(
      .FILT_LEN (FILT_LEN),
      .RST_VAL  (RST_VEC[i])
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_vec[i]),
      .filt_o (filt_vec[i])
    );
  end

  pf_recovery_timer #(
    .PRESCALE  (CLK_KHZ),
    .REC_TICKS (REC_MS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .vlow_i  (filt_vec[IDX_VLOW]),
    .state_o (pstate),
    .pwrup_o (pwrup)
  );

  assign mem_desel  = filt_vec[IDX_VLOW] || (pstate != PS_ONLINE);
  assign recov_busy = (pstate == PS_RECOVER);
  assign batt_sel   = filt_vec[IDX_VSW];
  assign wr_act     = !mem_desel && !host_ce_n && !host_we_n;

  pf_batt_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrup_i    (pwrup),
    .batt_low_i (filt_vec[IDX_BATT]),
    .wr_act_i   (wr_act),
    .bad_o      (batt_bad)
  );

  assign mem_ce_n = host_ce_n || mem_desel;
  assign mem_we_n = host_we_n || mem_desel || batt_bad;

  // R2
  desel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_desel |-> (mem_ce_n && mem_we_n));

  // R8
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_bad |-> mem_we_n);

  // R10
  busy_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_busy |-> mem_desel);
endmodule

// File: tb/pfail_guard_bench.sv
module pfail_guard_bench;
  localparam int L = 3;
  localparam int P = 8;
  localparam int T = 5;
  localparam int UP_LAT   = L + 3 + P * T;
  localparam int DOWN_LAT = L + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_low_raw = 1'b1, vcc_sw_raw = 1'b1, batt_low_raw = 1'b0;
  logic host_ce_n = 1'b1, host_we_n = 1'b1;
  logic mem_ce_n, mem_we_n, mem_desel, batt_sel, recov_busy, batt_bad;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfail_guard #(.CLK_KHZ(P), .REC_MS(T), .FILT_LEN(L)) u_pfail_guard (
    .clk(clk), .rst_n(rst_n), .vcc_low_raw(vcc_low_raw), .vcc_sw_raw(vcc_sw_raw),
    .batt_low_raw(batt_low_raw), .host_ce_n(host_ce_n), .host_we_n(host_we_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_desel(mem_desel),
    .batt_sel(batt_sel), .recov_busy(recov_busy), .batt_bad(batt_bad)
  );

  function automatic logic exp_ce(logic ce, logic desel);
    return ce | desel;
  endfunction

  function automatic logic exp_we(logic we, logic desel, logic bad);
    return we | desel | bad;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic power_up_check(input string req);
    step(L + 2);
    step(1);
    chk({req, " busy"}, recov_busy, 1'b1);      // R10
    step(UP_LAT - L - 4);
    chk({req, " still protected"}, mem_desel, 1'b1);
    step(1);
    chk({req, " released"}, mem_desel, 1'b0);
    chk({req, " busy done"}, recov_busy, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));

    // R1 reset state
    step(3);
    chk("R1 desel", mem_desel, 1'b1);
    chk("R1 ce", mem_ce_n, 1'b1);
    chk("R1 we", mem_we_n, 1'b1);
    chk("R1 bad", batt_bad, 1'b0);
    chk("R1 busy", recov_busy, 1'b0);
    chk("R1 bsel", batt_sel, 1'b1);
    rst_n = 1'b1;
    step(2);

    // R4 / R6 / R10 power-up with good battery
    vcc_low_raw = 1'b0;
    vcc_sw_raw  = 1'b0;
    step(L + 1);
    chk("R6 bsel before", batt_sel, 1'b1);
    step(1);
    chk("R6 bsel after", batt_sel, 1'b0);
    step(1);
    chk("R10 busy", recov_busy, 1'b1);
    step(UP_LAT - L - 4);
    chk("R4 still protected", mem_desel, 1'b1);
    step(1);
    chk("R4 released", mem_desel, 1'b0);
    chk("R10 busy done", recov_busy, 1'b0);
    chk("R7 good battery", batt_bad, 1'b0);

    // R9 random strobes while online
    for (int i = 0; i < 150; i++) begin
      host_ce_n = 1'($urandom_range(0, 1));
      host_we_n = 1'($urandom_range(0, 1));
      #1;
      chk("R9 ce", mem_ce_n, exp_ce(host_ce_n, 1'b0));
      chk("R9 we", mem_we_n, exp_we(host_we_n, 1'b0, 1'b0));
      step(1);
    end
    host_ce_n = 1'b1; host_we_n = 1'b1;

    // R6 switchover toggles do not touch deselect
    vcc_sw_raw = 1'b1;
    step(L + 2);
    chk("R6 bsel up", batt_sel, 1'b1);
    chk("R6 desel unaffected", mem_desel, 1'b0);
    vcc_sw_raw = 1'b0;
    step(L + 2);
    chk("R6 bsel down", batt_sel, 1'b0);

    // R3 glitch shorter than filter is ignored
    for (int g = 1; g < L; g++) begin
      vcc_low_raw = 1'b1;
      step(g);
      vcc_low_raw = 1'b0;
      for (int k = 0; k < 8; k++) begin
        step(1);
        chk("R3 glitch ignored", mem_desel, 1'b0);
      end
    end

    // R3 held power-down
    vcc_low_raw = 1'b1;
    step(DOWN_LAT - 1);
    chk("R3 before desel", mem_desel, 1'b0);
    step(1);
    chk("R3 desel", mem_desel, 1'b1);

    // R2 host ignored while deselected
    for (int i = 0; i < 30; i++) begin
      host_ce_n = 1'($urandom_range(0, 1));
      host_we_n = 1'($urandom_range(0, 1));
      #1;
      chk("R2 ce", mem_ce_n, 1'b1);
      chk("R2 we", mem_we_n, 1'b1);
      step(1);
    end
    host_ce_n = 1'b1; host_we_n = 1'b1;

    // R5 dip mid-recovery, battery low
    batt_low_raw = 1'b1;
    vcc_low_raw  = 1'b0;
    step(20);
    chk("R5 in recovery", recov_busy, 1'b1);
    vcc_low_raw = 1'b1;
    step(10);
    chk("R5 back off", recov_busy, 1'b0);
    chk("R5 desel", mem_desel, 1'b1);
    vcc_low_raw = 1'b0;
    power_up_check("R5 restart");
    chk("R7 low battery", batt_bad, 1'b1);

    // R8 first write swallowed
    host_ce_n = 1'b0; host_we_n = 1'b0;
    #1;
    chk("R8 ce passes", mem_ce_n, 1'b0);
    chk("R8 we blocked", mem_we_n, 1'b1);
    step(3);
    chk("R8 we still blocked", mem_we_n, 1'b1);
    chk("R8 flag held", batt_bad, 1'b1);
    host_we_n = 1'b1;
    #1;
    chk("R8 flag until end", batt_bad, 1'b1);
    step(1);
    chk("R8 flag cleared", batt_bad, 1'b0);
    host_we_n = 1'b0;
    #1;
    chk("R8 next write passes", mem_we_n, 1'b0);
    step(1);
    host_ce_n = 1'b1; host_we_n = 1'b1;

    // R7 re-sample with good battery
    vcc_low_raw = 1'b1;
    step(8);
    batt_low_raw = 1'b0;
    vcc_low_raw  = 1'b0;
    power_up_check("R7 cycle");
    chk("R7 good after cycle", batt_bad, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule